// File: doc/BRIEF.md
# Stack Pointer Execution Unit

This block is the stack datapath of a small 8-bit processor. It keeps a 16-bit stack pointer and carries out the nine stack-related operations once the controller has decoded them. These are push and pop of a register pair, loading the pointer from an immediate or from HL, swapping the two stack-top bytes with HL, stepping the pointer up or down by one, adding the pointer into HL, and doing nothing. The stack grows toward address zero. The pointer always holds the address of the lowest occupied byte.

The controller raises `start` for one cycle with an operation code, a pair selector, an immediate and the current BC, DE, HL and accumulator/flags words. The unit latches the operands and then runs one memory byte per cycle over a simple port: address, write data, read data and write enable, where read data is valid in the same cycle as the address. It finishes with a single-cycle `done`. In that cycle any register result is presented as a select, a 16-bit value and a write strobe, and the carry is presented the same way.

Operation codes are: 0 no-op, 1 push, 2 pop, 3 load immediate, 4 copy HL to SP, 5 exchange top with HL, 6 increment SP, 7 decrement SP, 8 add SP to HL. Codes 9 to 15 act as no-op. Pair selector codes are: 00 BC, 01 DE, 10 HL, and 11 for the accumulator/flags word (push, pop) or SP (load immediate).

Top module: `stack_unit`

## Requirements
- R1: After reset `sp` equals the parameter SP_INIT (default 0000H), and `done` and `mem_we` are low.
- R2: Push (op 1) writes the high byte of the selected pair to SP-1, then the low byte to SP-2, and leaves SP decremented by 2. `done` comes 3 cycles after `start` with exactly two write cycles. Selector 11 pushes the accumulator/flags word.
- R3: Pop (op 2) reads the low byte from SP and the high byte from SP+1, and returns them on `wb_data` with `wb_sel` equal to the selector. SP rises by 2 and `done` comes 3 cycles after `start`. Selector 11 targets the accumulator/flags word, with the accumulator in the high byte and the flags in the low byte.
- R4: Load immediate (op 3) with selector 11 sets SP to `imm` and writes back nothing. With any other selector it leaves SP alone and writes `imm` back to that pair. `done` comes 1 cycle after `start`.
- R5: Copy (op 4) sets SP to `hl_in`.
- R6: Exchange (op 5) writes old L to SP and old H to SP+1, returns the old memory word {SP+1, SP} as the new HL (`wb_sel` 10), and leaves SP unchanged. `done` comes 5 cycles after `start` with two write cycles.
- R7: Increment (op 6) and decrement (op 7) change SP by exactly 1 and raise neither `wb_en` nor `cy_we`.
- R8: Add (op 8) returns HL+SP as the new HL (`wb_sel` 10) and raises `cy_we` with `cy_out` equal to the carry out of bit 15. No other operation raises `cy_we`.
- R9: No-op (op 0) leaves SP unchanged, writes no memory, raises no write-back and still gives `done` after 1 cycle.
- R10: `done` is high for exactly one cycle, and `start` is ignored while an operation is in progress.
- R11: SP arithmetic and the push/pop addresses wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation, sampled when idle |
| op | input | 4 | Operation code |
| rp_sel | input | 2 | Register-pair selector |
| imm | input | 16 | Immediate for load |
| bc_in | input | 16 | Current BC |
| de_in | input | 16 | Current DE |
| hl_in | input | 16 | Current HL |
| psw_in | input | 16 | Current accumulator (high) and flags (low) |
| mem_rdata | input | 8 | Memory read byte, valid in the same cycle as the address |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| sp | output | 16 | Stack pointer |
| done | output | 1 | Operation complete, one cycle |
| wb_en | output | 1 | Register write-back strobe |
| wb_sel | output | 2 | Write-back target pair |
| wb_data | output | 16 | Write-back value |
| cy_we | output | 1 | Carry write strobe |
| cy_out | output | 1 | New carry value |

## Verification
Push and pop are run on BC, DE and the accumulator/flags word, and pushed values are popped back in reverse order. This shows whether byte order and LIFO order are right. A push and pop at SP=0001H straddle the top of the address space, which separates correct wrapping from an off-by-one address. Exchange runs on a word that was just pushed and confirms that the memory and HL both swap while SP holds. Add is tried with one sum that carries out of bit 15 and one that does not, so a stuck or mis-sourced carry shows up. A push with `start` held for a second cycle reveals any restart while the unit is busy.

// File: rtl/stack_unit.sv
module stack_unit #(
  parameter logic [15:0] SP_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op,
  input  logic [1:0]  rp_sel,
  input  logic [15:0] imm,
  input  logic [15:0] bc_in,
  input  logic [15:0] de_in,
  input  logic [15:0] hl_in,
  input  logic [15:0] psw_in,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic [15:0] sp,
  output logic        done,
  output logic        wb_en,
  output logic [1:0]  wb_sel,
  output logic [15:0] wb_data,
  output logic        cy_we,
  output logic        cy_out
);
  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_PUSH = 4'd1;
  localparam logic [3:0] OP_POP  = 4'd2;
  localparam logic [3:0] OP_LDSP = 4'd3;
  localparam logic [3:0] OP_COPY = 4'd4;
  localparam logic [3:0] OP_XCHG = 4'd5;
  localparam logic [3:0] OP_INC  = 4'd6;
  localparam logic [3:0] OP_DEC  = 4'd7;
  localparam logic [3:0] OP_ADD  = 4'd8;
  localparam logic [1:0] SEL_HL  = 2'b10;
  localparam logic [1:0] SEL_X   = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_B0, S_B1, S_B2, S_B3, S_FIN} state_t;

  state_t      st;
  logic [3:0]  op_q;
  logic [1:0]  sel_q;
  logic [15:0] dat_q;
  logic [15:0] rd_q;
  logic        cy_q;
  logic [15:0] pair_val;
  logic        idle;

  assign idle = (st == S_IDLE);
  assign pair_val = (rp_sel == 2'b00) ? bc_in :
                    (rp_sel == 2'b01) ? de_in :
                    (rp_sel == 2'b10) ? hl_in : psw_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sp    <= SP_INIT;
      op_q  <= OP_NOP;
      sel_q <= 2'b00;
      dat_q <= 16'h0000;
      rd_q  <= 16'h0000;
      cy_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q  <= op;
          sel_q <= rp_sel;
          st    <= S_FIN;
          case (op)
            OP_PUSH: begin dat_q <= pair_val; st <= S_B0; end
            OP_POP:  st <= S_B0;
            OP_XCHG: begin dat_q <= hl_in; st <= S_B0; end
            OP_LDSP: begin
              dat_q <= imm;
              if (rp_sel == SEL_X) sp <= imm;
            end
            OP_COPY: sp <= hl_in;
            OP_INC:  sp <= sp + 16'd1;
            OP_DEC:  sp <= sp - 16'd1;
            OP_ADD:  {cy_q, dat_q} <= {1'b0, hl_in} + {1'b0, sp};
            default: ;
          endcase
        end
        S_B0: begin
          if (op_q != OP_PUSH) rd_q[7:0] <= mem_rdata;
          st <= S_B1;
        end
        S_B1: begin
          if (op_q == OP_PUSH) begin
            sp <= sp - 16'd2;
            st <= S_FIN;
          end else begin
            rd_q[15:8] <= mem_rdata;
            if (op_q == OP_POP) begin
              sp <= sp + 16'd2;
              st <= S_FIN;
            end else begin
              st <= S_B2;
            end
          end
        end
        S_B2:    st <= S_B3;
        S_B3:    st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = sp;
    mem_wdata = 8'h00;
    mem_we    = 1'b0;
    case (st)
      S_B0: if (op_q == OP_PUSH) begin
        mem_addr  = sp - 16'd1;
        mem_wdata = dat_q[15:8];
        mem_we    = 1'b1;
      end
      S_B1: if (op_q == OP_PUSH) begin
        mem_addr  = sp - 16'd2;
        mem_wdata = dat_q[7:0];
        mem_we    = 1'b1;
      end else begin
        mem_addr  = sp + 16'd1;
      end
      S_B2: begin
        mem_wdata = dat_q[7:0];
        mem_we    = 1'b1;
      end
      S_B3: begin
        mem_addr  = sp + 16'd1;
        mem_wdata = dat_q[15:8];
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

  assign done    = (st == S_FIN);
  assign wb_en   = done && ((op_q == OP_POP) || (op_q == OP_XCHG) || (op_q == OP_ADD) ||
                            ((op_q == OP_LDSP) && (sel_q != SEL_X)));
  assign wb_sel  = ((op_q == OP_XCHG) || (op_q == OP_ADD)) ? SEL_HL : sel_q;
  assign wb_data = ((op_q == OP_POP) || (op_q == OP_XCHG)) ? rd_q : dat_q;
  assign cy_we   = done && (op_q == OP_ADD);
  assign cy_out  = cy_q;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle) |=> $stable(op_q));
  a_r7_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && op == OP_INC) |=> sp == $past(sp) + 16'd1);
  a_r7_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && op == OP_DEC) |=> sp == $past(sp) - 16'd1);
  a_r5_copy_hl: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && op == OP_COPY) |=> sp == $past(hl_in));
  a_r6_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && op_q == OP_XCHG) |=> $stable(sp));
  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && op_q == OP_NOP) |-> (!mem_we && !wb_en && !cy_we));
  a_r2_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !idle && !done);
endmodule

// File: tb/sim_stack_unit.sv
module sim_stack_unit;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [15:0] sp;
    bit          wb_en;
    logic [1:0]  sel;
    logic [15:0] data;
    bit          cy_we;
    bit          cy;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] op = 4'd0;
  logic [1:0] rp_sel = 2'b00;
  logic [15:0] imm = 16'h0, bc = 16'h0, de = 16'h0, hl = 16'h0, psw = 16'h0;
  logic [7:0] mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_we;
  logic [15:0] sp;
  logic done, wb_en, cy_we, cy_out;
  logic [1:0] wb_sel;
  logic [15:0] wb_data;

  logic [7:0] mem [0:255];
  exp_t sb[$];
  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rp_sel(rp_sel), .imm(imm),
    .bc_in(bc), .de_in(de), .hl_in(hl), .psw_in(psw), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .sp(sp), .done(done),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data), .cy_we(cy_we), .cy_out(cy_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [15:0] s, input bit we, input logic [1:0] sl,
                              input logic [15:0] d, input bit cwe, input bit c, input string t);
    exp_t e;
    e.sp = s; e.wb_en = we; e.sel = sl; e.data = d; e.cy_we = cwe; e.cy = c; e.tag = t;
    return e;
  endfunction

  always @(negedge clk) if (rst_n && done) begin
    if (sb.size() == 0) begin
      chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
    end else begin
      exp_t e;
      e = sb.pop_front();
      chk(sp == e.sp, e.tag, "sp", sp, e.sp);
      chk(wb_en == e.wb_en, e.tag, "wb_en", wb_en, e.wb_en);
      if (e.wb_en) begin
        chk(wb_sel == e.sel, e.tag, "wb_sel", wb_sel, e.sel);
        chk(wb_data == e.data, e.tag, "wb_data", wb_data, e.data);
      end
      chk(cy_we == e.cy_we, e.tag, "cy_we", cy_we, e.cy_we);
      if (e.cy_we) chk(cy_out == e.cy, e.tag, "cy_out", cy_out, e.cy);
    end
  end

  task automatic do_op(input logic [3:0] o, input logic [1:0] s, input logic [15:0] im,
                       input int lat, input int nwr, input exp_t e, input bit hold);
    int cyc = 0;
    int wr = 0;
    sb.push_back(e);
    @(negedge clk);
    op = o; rp_sel = s; imm = im; start = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (!(hold && cyc == 1)) start = 1'b0;
      if (mem_we) wr++;
      if (done || cyc > 20) break;
    end
    chk(cyc == lat, e.tag, "latency", cyc, lat);
    chk(wr == nwr, e.tag, "write cycles", wr, nwr);
    @(negedge clk);
    chk(!done, "R10", "done width", done, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(sp == 16'h0000, "R1", "reset sp", sp, 16'h0000);
    chk(!done, "R1", "reset done", done, 1'b0);
    chk(!mem_we, "R1", "reset mem_we", mem_we, 1'b0);
    rst_n = 1'b1;

    // R4 load immediate into SP, then into DE
    do_op(4'd3, 2'b11, 16'h3008, 1, 0, mk(16'h3008, 0, 2'b00, 16'h0, 0, 0, "R4"), 0);
    do_op(4'd3, 2'b01, 16'hBEEF, 1, 0, mk(16'h3008, 1, 2'b01, 16'hBEEF, 0, 0, "R4"), 0);

    // R2 push BC and the accumulator/flags word
    bc = 16'h1234;
    do_op(4'd1, 2'b00, 16'h0, 3, 2, mk(16'h3006, 0, 2'b00, 16'h0, 0, 0, "R2"), 0);
    chk(mem[8'h07] == 8'h12, "R2", "high byte at SP-1", mem[8'h07], 8'h12);
    chk(mem[8'h06] == 8'h34, "R2", "low byte at SP-2", mem[8'h06], 8'h34);
    psw = 16'hA5C3;
    do_op(4'd1, 2'b11, 16'h0, 3, 2, mk(16'h3004, 0, 2'b00, 16'h0, 0, 0, "R2"), 0);
    chk(mem[8'h05] == 8'hA5, "R2", "accumulator byte", mem[8'h05], 8'hA5);
    chk(mem[8'h04] == 8'hC3, "R2", "flags byte", mem[8'h04], 8'hC3);

    // R3 pop in reverse order
    do_op(4'd2, 2'b10, 16'h0, 3, 0, mk(16'h3006, 1, 2'b10, 16'hA5C3, 0, 0, "R3"), 0);
    do_op(4'd2, 2'b11, 16'h0, 3, 0, mk(16'h3008, 1, 2'b11, 16'h1234, 0, 0, "R3"), 0);

    // R10 start held high during a push must not start a second one
    de = 16'h5566;
    do_op(4'd1, 2'b01, 16'h0, 3, 2, mk(16'h3006, 0, 2'b00, 16'h0, 0, 0, "R10"), 1);
    chk(sp == 16'h3006, "R10", "sp after held start", sp, 16'h3006);

    // R6 exchange
    hl = 16'h9ABC;
    do_op(4'd5, 2'b00, 16'h0, 5, 2, mk(16'h3006, 1, 2'b10, 16'h5566, 0, 0, "R6"), 0);
    chk(mem[8'h06] == 8'hBC, "R6", "L to SP", mem[8'h06], 8'hBC);
    chk(mem[8'h07] == 8'h9A, "R6", "H to SP+1", mem[8'h07], 8'h9A);

    // R5 copy, R7 step, R9 no-op
    hl = 16'h4010;
    do_op(4'd4, 2'b00, 16'h0, 1, 0, mk(16'h4010, 0, 2'b00, 16'h0, 0, 0, "R5"), 0);
    do_op(4'd6, 2'b00, 16'h0, 1, 0, mk(16'h4011, 0, 2'b00, 16'h0, 0, 0, "R7"), 0);
    do_op(4'd7, 2'b00, 16'h0, 1, 0, mk(16'h4010, 0, 2'b00, 16'h0, 0, 0, "R7"), 0);
    do_op(4'd0, 2'b10, 16'h0, 1, 0, mk(16'h4010, 0, 2'b00, 16'h0, 0, 0, "R9"), 0);

    // R11 wrap on increment and decrement
    do_op(4'd3, 2'b11, 16'hFFFF, 1, 0, mk(16'hFFFF, 0, 2'b00, 16'h0, 0, 0, "R4"), 0);
    do_op(4'd6, 2'b00, 16'h0, 1, 0, mk(16'h0000, 0, 2'b00, 16'h0, 0, 0, "R11"), 0);
    do_op(4'd7, 2'b00, 16'h0, 1, 0, mk(16'hFFFF, 0, 2'b00, 16'h0, 0, 0, "R11"), 0);

    // R8 add with and without carry out
    hl = 16'h0001;
    do_op(4'd8, 2'b00, 16'h0, 1, 0, mk(16'hFFFF, 1, 2'b10, 16'h0000, 1, 1, "R8"), 0);
    do_op(4'd3, 2'b11, 16'h1000, 1, 0, mk(16'h1000, 0, 2'b00, 16'h0, 0, 0, "R4"), 0);
    hl = 16'h2000;
    do_op(4'd8, 2'b00, 16'h0, 1, 0, mk(16'h1000, 1, 2'b10, 16'h3000, 1, 0, "R8"), 0);

    // R11 push and pop across the top of the address space
    do_op(4'd3, 2'b11, 16'h0001, 1, 0, mk(16'h0001, 0, 2'b00, 16'h0, 0, 0, "R4"), 0);
    bc = 16'hAB12;
    do_op(4'd1, 2'b00, 16'h0, 3, 2, mk(16'hFFFF, 0, 2'b00, 16'h0, 0, 0, "R11"), 0);
    chk(mem[8'h00] == 8'hAB, "R11", "high byte at 0000", mem[8'h00], 8'hAB);
    chk(mem[8'hFF] == 8'h12, "R11", "low byte at FFFF", mem[8'hFF], 8'h12);
    do_op(4'd2, 2'b00, 16'h0, 3, 0, mk(16'h0001, 1, 2'b00, 16'hAB12, 0, 0, "R11"), 0);

    chk(sb.size() == 0, "R10", "pending results", sb.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule